// File: doc/BRIEF.md
# Bidirectional Linear Ramp Generator

This block produces a 32-bit control value that moves linearly between a programmable floor and ceiling. The rising and falling slopes each have their own increment and their own step interval, counted in system clocks. A direction input selects the slope and a hold input freezes the generator. A flag output reports whenever the value sits on either bound.

Settings are presented on the configuration inputs. They take effect in one cycle, when the load strobe is pulsed. The load also places the ramp at the floor and restarts the step timer. A destination setting chooses how the ramp feeds a downstream oscillator. It can be used as a full 32-bit tuning word, as a 16-bit phase word taken from the top bits, or as a 14-bit amplitude word taken from the top bits. Typical uses are frequency chirps, phase sweeps and amplitude envelopes. In these uses the sweep direction is turned by an outside event.

Top module: `ramp_gen`

## Requirements
- R1: After reset the ramp value is 0, the floor is 0, the ceiling is all ones, both increments and both intervals are 0, the destination is frequency, and the at-limit flag is 1.
- R2: A cycle with `cfg_load` high captures every configuration input. The ramp value equals `cfg_lo` after that clock edge, and the step timer restarts using the interval of the slope that `ramp_dir` selects. A load takes priority over hold.
- R3: With `ramp_dir` high and no hold, the value rises by `cfg_step_up` once every N clocks, where N is the rising interval. An interval of 0 acts as 1.
- R4: With `ramp_dir` low and no hold, the value falls by `cfg_step_dn` once every M clocks, where M is the falling interval. An interval of 0 acts as 1.
- R5: A rising step that would pass the ceiling, or wrap past 2^32, yields exactly the ceiling. The value then stays there while the direction remains high.
- R6: A falling step that would pass the floor, or go below zero, yields exactly the floor. The value then stays there while the direction remains low.
- R7: A change of `ramp_dir` is taken in the first clock in which it is seen, and no step happens in that clock. The ramp continues from its current value with the other slope's increment, and its first step comes a full interval of the new slope later.
- R8: While `ramp_hold` is high and no load is applied, the value, the direction in use and the remaining interval count are frozen. After release, timing continues from where it stopped.
- R9: `at_limit` is 1 exactly when the ramp value equals the floor or the ceiling, and it drops as soon as the value leaves the bound.
- R10: `ctrl_word` routes the value by the loaded destination code. Code 0 gives all 32 bits. Code 1 gives bits 31:16 in bits 15:0. Code 2 gives bits 31:18 in bits 13:0. Code 3 gives zero. All unused upper bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Update strobe: capture configuration, restart ramp at floor |
| cfg_lo | input | 32 | Floor of the ramp |
| cfg_hi | input | 32 | Ceiling of the ramp |
| cfg_step_up | input | 32 | Increment per rising step |
| cfg_step_dn | input | 32 | Decrement per falling step |
| cfg_intv_up | input | 16 | Clocks between rising steps |
| cfg_intv_dn | input | 16 | Clocks between falling steps |
| cfg_dest | input | 2 | Destination code (0 frequency, 1 phase, 2 amplitude, 3 none) |
| ramp_dir | input | 1 | 1 rises, 0 falls |
| ramp_hold | input | 1 | Freeze the generator while high |
| ramp_value | output | 32 | Current ramp accumulator |
| ctrl_word | output | 32 | Value routed to the selected destination |
| at_limit | output | 1 | Value equals floor or ceiling |

## Verification
Some properties are checked on every cycle. The value stays inside the loaded bounds. It never falls while the rising slope is active and never rises while the falling slope is active. It does not move during a hold. The remaining interval count never exceeds the interval of the active slope, and an amplitude word keeps its upper bits clear. Other behaviour can only be shown by the bench's scenarios against its reference model. This covers the exact step spacing of each asymmetric slope and the clamping at a wrapping sum or borrow. It also covers the step-free cycle at a reversal, resuming after a hold with the remaining count, the flag clearing and the destination routing.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

  typedef enum logic [1:0] {
    DST_FREQ  = 2'd0,
    DST_PHASE = 2'd1,
    DST_AMP   = 2'd2,
    DST_NONE  = 2'd3
  } ramp_dest_e;

endpackage

// File: rtl/ramp_cfg.sv
module ramp_cfg
  import ramp_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] lo_in,
  input  logic [ACC_W-1:0] hi_in,
  input  logic [ACC_W-1:0] up_in,
  input  logic [ACC_W-1:0] dn_in,
  input  logic [INT_W-1:0] iup_in,
  input  logic [INT_W-1:0] idn_in,
  input  logic [1:0]       dest_in,
  output logic [ACC_W-1:0] lo_q,
  output logic [ACC_W-1:0] hi_q,
  output logic [ACC_W-1:0] up_q,
  output logic [ACC_W-1:0] dn_q,
  output logic [INT_W-1:0] iup_q,
  output logic [INT_W-1:0] idn_q,
  output ramp_dest_e       dest_q
);

  // shadow set: all fields move together on the update strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '1;
      up_q   <= '0;
      dn_q   <= '0;
      iup_q  <= '0;
      idn_q  <= '0;
      dest_q <= DST_FREQ;
    end else if (load) begin
      lo_q   <= lo_in;
      hi_q   <= hi_in;
      up_q   <= up_in;
      dn_q   <= dn_in;
      iup_q  <= iup_in;
      idn_q  <= idn_in;
      dest_q <= ramp_dest_e'(dest_in);
    end
  end

endmodule

// File: rtl/ramp_timer.sv
module ramp_timer #(
  parameter int INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             hold,
  input  logic             dir_in,
  input  logic [INT_W-1:0] iup_act,
  input  logic [INT_W-1:0] idn_act,
  input  logic [INT_W-1:0] iup_new,
  input  logic [INT_W-1:0] idn_new,
  output logic             fire,
  output logic             dir_q
);

  logic [INT_W-1:0] cnt_q, cnt_d;
  logic             dir_d;
  logic             tmr_en;

  // an interval of 0 behaves like 1
  function automatic logic [INT_W-1:0] reload_of(input logic [INT_W-1:0] n);
    return (n == '0) ? '0 : n - 1'b1;
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    dir_d  = dir_q;
    fire   = 1'b0;
    tmr_en = load | ~hold;
    if (load) begin
      dir_d = dir_in;
      cnt_d = reload_of(dir_in ? iup_new : idn_new);
    end else if (!hold) begin
      if (dir_in != dir_q) begin
        dir_d = dir_in;
        cnt_d = reload_of(dir_in ? iup_act : idn_act);
      end else if (cnt_q == '0) begin
        fire  = 1'b1;
        cnt_d = reload_of(dir_q ? iup_act : idn_act);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (tmr_en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  // R3 / R4: remaining count never exceeds the active slope's interval
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (dir_q ? iup_act : idn_act));

endmodule

// File: rtl/ramp_accum.sv
module ramp_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] lo_new,
  input  logic             fire,
  input  logic             dir_up,
  input  logic [ACC_W-1:0] step_up,
  input  logic [ACC_W-1:0] step_dn,
  input  logic [ACC_W-1:0] lim_lo,
  input  logic [ACC_W-1:0] lim_hi,
  output logic [ACC_W-1:0] acc_q,
  output logic             at_lim
);

  localparam int EXT_W = ACC_W + 1;

  logic [EXT_W-1:0] sum_w, dif_w;
  logic [ACC_W-1:0] up_val, dn_val, acc_d;
  logic             acc_en;

  always_comb begin
    sum_w  = {1'b0, acc_q} + {1'b0, step_up};
    dif_w  = {1'b0, acc_q} - {1'b0, step_dn};
    up_val = (sum_w[ACC_W] || (sum_w[ACC_W-1:0] > lim_hi)) ? lim_hi : sum_w[ACC_W-1:0];
    dn_val = (dif_w[ACC_W] || (dif_w[ACC_W-1:0] < lim_lo)) ? lim_lo : dif_w[ACC_W-1:0];
    acc_en = load | fire;
    acc_d  = load ? lo_new : (dir_up ? up_val : dn_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign at_lim = (acc_q == lim_hi) || (acc_q == lim_lo);

  // R5 / R6: value stays inside a well-ordered pair of bounds
  p_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_lo <= lim_hi) |-> ((acc_q >= lim_lo) && (acc_q <= lim_hi)));

  // R3: rising slope never lowers the value
  p_rise_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && dir_up) |=> (acc_q >= $past(acc_q)));

  // R4: falling slope never raises the value
  p_fall_mono_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !dir_up) |=> (acc_q <= $past(acc_q)));

endmodule

// File: rtl/ramp_route.sv
module ramp_route
  import ramp_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int PH_W  = 16,
  parameter int AM_W  = 14
) (
  input  logic [ACC_W-1:0] acc,
  input  ramp_dest_e       dest,
  output logic [ACC_W-1:0] word
);

  localparam int PH_PAD = ACC_W - PH_W;
  localparam int AM_PAD = ACC_W - AM_W;

  always_comb begin
    unique case (dest)
      DST_FREQ:  word = acc;
      DST_PHASE: word = {{PH_PAD{1'b0}}, acc[ACC_W-1 -: PH_W]};
      DST_AMP:   word = {{AM_PAD{1'b0}}, acc[ACC_W-1 -: AM_W]};
      default:   word = '0;
    endcase
  end

endmodule

// File: rtl/ramp_gen.sv
module ramp_gen
  import ramp_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int INT_W = 16,
  parameter int PH_W  = 16,
  parameter int AM_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [ACC_W-1:0] cfg_lo,
  input  logic [ACC_W-1:0] cfg_hi,
  input  logic [ACC_W-1:0] cfg_step_up,
  input  logic [ACC_W-1:0] cfg_step_dn,
  input  logic [INT_W-1:0] cfg_intv_up,
  input  logic [INT_W-1:0] cfg_intv_dn,
  input  logic [1:0]       cfg_dest,
  input  logic             ramp_dir,
  input  logic             ramp_hold,
  output logic [ACC_W-1:0] ramp_value,
  output logic [ACC_W-1:0] ctrl_word,
  output logic             at_limit
);

  // reset asserts at once, releases on a clock edge
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [ACC_W-1:0] lo_q, hi_q, up_q, dn_q;
  logic [INT_W-1:0] iup_q, idn_q;
  ramp_dest_e       dest_q;
  logic             fire, dir_q;

  ramp_cfg #(.ACC_W(ACC_W), .INT_W(INT_W)) u_cfg (
    .clk(clk), .rst_n(rst_s2), .load(cfg_load),
    .lo_in(cfg_lo), .hi_in(cfg_hi), .up_in(cfg_step_up), .dn_in(cfg_step_dn),
    .iup_in(cfg_intv_up), .idn_in(cfg_intv_dn), .dest_in(cfg_dest),
    .lo_q(lo_q), .hi_q(hi_q), .up_q(up_q), .dn_q(dn_q),
    .iup_q(iup_q), .idn_q(idn_q), .dest_q(dest_q)
  );

  ramp_timer #(.INT_W(INT_W)) u_tmr (
    .clk(clk), .rst_n(rst_s2), .load(cfg_load), .hold(ramp_hold),
    .dir_in(ramp_dir), .iup_act(iup_q), .idn_act(idn_q),
    .iup_new(cfg_intv_up), .idn_new(cfg_intv_dn),
    .fire(fire), .dir_q(dir_q)
  );

  ramp_accum #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_s2), .load(cfg_load), .lo_new(cfg_lo),
    .fire(fire), .dir_up(dir_q), .step_up(up_q), .step_dn(dn_q),
    .lim_lo(lo_q), .lim_hi(hi_q), .acc_q(ramp_value), .at_lim(at_limit)
  );

  ramp_route #(.ACC_W(ACC_W), .PH_W(PH_W), .AM_W(AM_W)) u_route (
    .acc(ramp_value), .dest(dest_q), .word(ctrl_word)
  );

  // R8: a hold without load leaves the value untouched
  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    (ramp_hold && !cfg_load) |=> $stable(ramp_value));

  // R10: amplitude routing leaves the upper bits clear
  p_route_amp_r10: assert property (@(posedge clk) disable iff (!rst_s2)
    (dest_q == DST_AMP) |-> (ctrl_word[ACC_W-1:AM_W] == '0));

endmodule

// File: tb/ramp_gen_bench.sv
module ramp_gen_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load, ramp_dir, ramp_hold;
  logic [31:0] cfg_lo, cfg_hi, cfg_step_up, cfg_step_dn;
  logic [15:0] cfg_intv_up, cfg_intv_dn;
  logic [1:0]  cfg_dest;
  logic [31:0] ramp_value, ctrl_word;
  logic        at_limit;

  always #4 clk = ~clk;

  ramp_gen u_ramp_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_step_up(cfg_step_up), .cfg_step_dn(cfg_step_dn),
    .cfg_intv_up(cfg_intv_up), .cfg_intv_dn(cfg_intv_dn), .cfg_dest(cfg_dest),
    .ramp_dir(ramp_dir), .ramp_hold(ramp_hold),
    .ramp_value(ramp_value), .ctrl_word(ctrl_word), .at_limit(at_limit)
  );

  typedef struct {
    logic [31:0] val;
    logic [31:0] word;
    logic        flag;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference state
  logic [31:0] m_acc, m_lo, m_hi, m_up, m_dn;
  logic [15:0] m_iup, m_idn, m_cnt;
  logic [1:0]  m_dest;
  logic        m_dir;

  function automatic logic [31:0] route(input logic [31:0] v, input logic [1:0] d);
    case (d)
      2'd0:    return v;
      2'd1:    return v >> 16;
      2'd2:    return v >> 18;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [15:0] first_cnt(input logic [15:0] n);
    return (n == 0) ? 16'd0 : n - 16'd1;
  endfunction

  task automatic model_step(input logic ld, input logic dr, input logic hd);
    longint s;
    if (ld) begin
      m_lo = cfg_lo; m_hi = cfg_hi; m_up = cfg_step_up; m_dn = cfg_step_dn;
      m_iup = cfg_intv_up; m_idn = cfg_intv_dn; m_dest = cfg_dest;
      m_acc = cfg_lo; m_dir = dr;
      m_cnt = first_cnt(dr ? cfg_intv_up : cfg_intv_dn);
    end else if (!hd) begin
      if (dr != m_dir) begin
        m_dir = dr;
        m_cnt = first_cnt(dr ? m_iup : m_idn);
      end else if (m_cnt == 0) begin
        if (m_dir) begin
          s = longint'(m_acc) + longint'(m_up);
          m_acc = (s > longint'(m_hi)) ? m_hi : s[31:0];
        end else begin
          s = longint'(m_acc) - longint'(m_dn);
          m_acc = (s < longint'(m_lo)) ? m_lo : s[31:0];
        end
        m_cnt = first_cnt(m_dir ? m_iup : m_idn);
      end else begin
        m_cnt = m_cnt - 16'd1;
      end
    end
  endtask

  // driver: one vector per clock, applied on the falling edge
  task automatic drive(input logic ld, input logic dr, input logic hd, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_load = ld; ramp_dir = dr; ramp_hold = hd;
    model_step(ld, dr, hd);
    e.val  = m_acc;
    e.word = route(m_acc, m_dest);
    e.flag = (m_acc == m_lo) || (m_acc == m_hi);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic set_cfg(input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] su, input logic [31:0] sd,
                         input logic [15:0] iu, input logic [15:0] idn,
                         input logic [1:0] d);
    cfg_lo = lo; cfg_hi = hi; cfg_step_up = su; cfg_step_dn = sd;
    cfg_intv_up = iu; cfg_intv_dn = idn; cfg_dest = d;
  endtask

  // monitor: compares after each rising edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0 && !done) begin
      exp_t e;
      bit   bad;
      e   = q.pop_front();
      bad = 0;
      n_vec++;
      if (ramp_value !== e.val) begin
        bad = 1;
        $display("FAIL %s ramp_value got %h expected %h", e.tag, ramp_value, e.val);
      end
      if (at_limit !== e.flag) begin
        bad = 1;
        $display("FAIL R9 (%s) at_limit got %b expected %b", e.tag, at_limit, e.flag);
      end
      if (ctrl_word !== e.word) begin
        bad = 1;
        $display("FAIL R10 (%s) ctrl_word got %h expected %h", e.tag, ctrl_word, e.word);
      end
      if (bad) n_bad++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired, expected run to complete");
    n_bad++;
    finish_run();
  end

  logic [15:0] lf;

  initial begin
    rst_n = 1'b0; cfg_load = 0; ramp_dir = 1; ramp_hold = 0;
    set_cfg(32'h0, 32'h0, 32'h0, 32'h0, 16'h0, 16'h0, 2'd0);
    m_acc = 0; m_lo = 0; m_hi = 32'hFFFF_FFFF; m_up = 0; m_dn = 0;
    m_iup = 0; m_idn = 0; m_dest = 0; m_dir = 1; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state at the ports
    n_vec++;
    if (ramp_value !== 32'd0 || ctrl_word !== 32'd0 || at_limit !== 1'b1) begin
      n_bad++;
      $display("FAIL R1 reset got %h/%h/%b expected 0/0/1", ramp_value, ctrl_word, at_limit);
    end
    for (int i = 0; i < 10; i++) drive(0, i[1], 0, "R1");

    // R2 / R3 / R5: asymmetric slopes, climb to the ceiling and stay
    set_cfg(32'h0000_1000, 32'h0001_0000, 32'h300, 32'h1000, 16'd3, 16'd5, 2'd0);
    drive(1, 1, 0, "R2");
    for (int i = 0; i < 60; i++)  drive(0, 1, 0, "R3");
    for (int i = 0; i < 220; i++) drive(0, 1, 0, "R5");

    // R4 / R7 / R6: reverse, fall to the floor and stay
    for (int i = 0; i < 30; i++)  drive(0, 0, 0, "R7");
    for (int i = 0; i < 70; i++)  drive(0, 0, 0, "R6");

    // R7: reversals mid-ramp
    for (int i = 0; i < 40; i++)  drive(0, 1, 0, "R7");
    for (int i = 0; i < 12; i++)  drive(0, 0, 0, "R7");
    for (int i = 0; i < 20; i++)  drive(0, 1, 0, "R4");

    // R8: hold pulses and reversals, phase destination
    set_cfg(32'h2000_0000, 32'h6000_0000, 32'h0123_4567, 32'h0345_6789, 16'd2, 16'd7, 2'd1);
    drive(1, 1, 0, "R2");
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      logic d, h;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d = (lf[3:0] == 4'd0) ? ~ramp_dir : ramp_dir;
      h = (lf[7:5] == 3'd0);
      drive(0, d, h, "R8");
    end

    // R8 / R2: load during hold wins
    set_cfg(32'h0000_0100, 32'h0000_8000, 32'h10, 32'h20, 16'd4, 16'd2, 2'd2);
    drive(1, 0, 1, "R2");
    for (int i = 0; i < 5; i++) drive(0, 1, 1, "R8");
    for (int i = 0; i < 20; i++) drive(0, 1, 0, "R3");

    // R5 / R6: wrapping sum and borrow, interval 0, amplitude routing
    set_cfg(32'h0, 32'hFFFF_FFFF, 32'h4000_0000, 32'h7000_0000, 16'd0, 16'd2, 2'd2);
    drive(1, 1, 0, "R2");
    for (int i = 0; i < 8; i++)  drive(0, 1, 0, "R5");
    for (int i = 0; i < 15; i++) drive(0, 0, 0, "R6");
    for (int i = 0; i < 4; i++)  drive(0, 1, 0, "R3");

    // R10: destination none, then phase
    set_cfg(32'h1234_5678, 32'h9ABC_DEF0, 32'h0101_0101, 32'h0202_0202, 16'd1, 16'd1, 2'd3);
    drive(1, 1, 0, "R10");
    for (int i = 0; i < 10; i++) drive(0, 1, 0, "R10");
    set_cfg(32'h1234_5678, 32'h9ABC_DEF0, 32'h0101_0101, 32'h0202_0202, 16'd1, 16'd1, 2'd1);
    drive(1, 0, 0, "R10");
    for (int i = 0; i < 10; i++) drive(0, 1, 0, "R10");

    drive(0, 1, 1, "R8");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule